// File: doc/BRIEF.md
# Nibble-Addressed Double-Buffered Converter Input Port

This block is the digital front end of a 10-bit voltage-output converter. It is a synchronous model of a parallel processor write port. A host drives an 8-line data bus, two address lines, an active-low select and an active-low write strobe. With these it fills a 12-bit staging register that is split into three 4-bit nibbles. A host with a 4-bit bus writes the nibbles one at a time. A host with a wider bus writes the two lower nibbles together in one 8-bit access and then writes the top nibble.

A separate active-low load strobe copies the staging register into the 10-bit code register that drives the converter. While the load strobe is held low, the code register follows the staging register. When the load strobe rises, the code register keeps its value. An active-low clear, and the power-on reset, zero the code register. The two lowest staging bits sit below the converter's LSB and must be written as zero. A sticky flag reports any write that breaks this rule.

All host strobes are asynchronous to the system clock. Each one passes through a synchronizer before it is used. A staging write commits on the synchronized rising edge of the write strobe.

Top module: `dac_nibble_if`

## Requirements
- R1: The staging register is 12 bits wide, with three 4-bit nibbles: low = bits 3..0, middle = bits 7..4, high = bits 11..8. Bit 0 and bit 1 of the low nibble are the sub-LSB bits. The output code is staging bits 11..2.
- R2: A write with address {a1,a0} = 2'b11 loads the high nibble from bus lines 3..0. Bus lines 7..4 are ignored for this write.
- R3: A write with address 2'b01 loads the middle nibble from bus lines 7..4.
- R4: A write with address 2'b10 loads the low nibble from bus lines 3..0.
- R5: A write with address 2'b00 loads the low and middle nibbles together from all eight bus lines, in one access.
- R6: A staging write commits only when select and write were both low, write then rises, and clear is high. With select high, or with clear low, a write strobe changes nothing.
- R7: While the load strobe stays high, the code register holds its value, whatever is written to the staging register.
- R8: While the load strobe is low, the code register follows the staging register, including a high-nibble write made during that time. When the load strobe rises, the code register keeps the last value it followed.
- R9: Clear low forces the code to zero at once, without waiting for a clock edge. The staging register keeps its contents, so a later load restores the earlier code.
- R10: Power-on reset zeros the staging register, the code register and the error flag.
- R11: A write that loads the low nibble (address 2'b10 or 2'b00) with either sub-LSB bit set to 1 sets the error flag. The flag stays set until power-on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low; commits on its rising edge |
| ld_n | input | 1 | Load strobe, active low; code register is transparent while low |
| clr_n | input | 1 | Clear, active low, asynchronous on the code register |
| addr | input | 2 | Nibble select {a1,a0} |
| bus | input | 8 | Parallel data bus |
| code | output | 10 | Converter code register |
| sub_lsb_err | output | 1 | Sticky flag for a nonzero sub-LSB write |

## Verification
The checker module checks four behaviours on every cycle:
- the code register stays stable while the synchronized load strobe is high;
- the code register tracks the staging register one cycle behind while the load strobe is low;
- the code register reads zero whenever clear is low;
- the staging register is unchanged when no write edge is present or when clear is active.

It also checks that the error flag, once set, never falls.

Only the bench scenarios can show the rest: the nibble routing for each address, the decoded content of each write, that a write with select high or clear low is dropped, that clear leaves the staging data for a later load, that power-on reset wipes the staging register, and that the sub-LSB rule applies to combined writes.

// File: rtl/dacif_pkg.sv
package dacif_pkg;

   // Nibble select as {a1,a0}; values are decoded by the staging register.
   typedef enum logic [1:0] {
      SEL_LOW_MID = 2'b00,
      SEL_MID     = 2'b01,
      SEL_LOW     = 2'b10,
      SEL_HIGH    = 2'b11
   } nib_sel_e;

   localparam int unsigned NUM_NIBBLES = 3;

endpackage

// File: rtl/dacif_sync.sv
module dacif_sync #(
   parameter int unsigned   W       = 1,
   parameter int unsigned   STAGES  = 2,
   parameter logic [W-1:0]  RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < int'(STAGES); s++) stg[s] <= RST_VAL;
      end else begin
         stg[0] <= d;
         for (int s = 1; s < int'(STAGES); s++) stg[s] <= stg[s-1];
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/dacif_input_reg.sv
module dacif_input_reg
   import dacif_pkg::*;
#(
   parameter int unsigned NIB_W = 4,
   parameter int unsigned SUB_W = 2,
   localparam int unsigned BUS_W = 2 * NIB_W,
   localparam int unsigned REG_W = NUM_NIBBLES * NIB_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  nib_sel_e         sel,
   input  logic [BUS_W-1:0] data,
   output logic [REG_W-1:0] in_reg,
   output logic             sub_err
);

   logic [NUM_NIBBLES-1:0] nib_en;

   always_comb begin
      nib_en    = '0;
      nib_en[0] = wr_en && (sel == SEL_LOW || sel == SEL_LOW_MID);
      nib_en[1] = wr_en && (sel == SEL_MID || sel == SEL_LOW_MID);
      nib_en[2] = wr_en && (sel == SEL_HIGH);
   end

   for (genvar i = 0; i < int'(NUM_NIBBLES); i++) begin : g_nib
      logic [NIB_W-1:0] q;
      logic [NIB_W-1:0] src;
      // Middle nibble uses the upper bus lines; low and high share the lower lines.
      if (i == 1) begin : g_upper
         assign src = data[BUS_W-1:NIB_W];
      end else begin : g_lower
         assign src = data[NIB_W-1:0];
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        q <= '0;
         else if (nib_en[i]) q <= src;
      end
      assign in_reg[i*NIB_W +: NIB_W] = q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           sub_err <= 1'b0;
      else if (nib_en[0] && |data[SUB_W-1:0]) sub_err <= 1'b1;
   end

endmodule

// File: rtl/dacif_output_reg.sv
module dacif_output_reg #(
   parameter int unsigned CODE_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              follow,
   input  logic [CODE_W-1:0] src,
   output logic [CODE_W-1:0] code
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      code <= '0;
      else if (follow) code <= src;
   end

endmodule

// File: rtl/dac_nibble_if.sv
module dac_nibble_if
   import dacif_pkg::*;
#(
   parameter int unsigned NIB_W       = 4,
   parameter int unsigned SUB_W       = 2,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                                clk,
   input  logic                                por_n,
   input  logic                                cs_n,
   input  logic                                wr_n,
   input  logic                                ld_n,
   input  logic                                clr_n,
   input  logic [1:0]                          addr,
   input  logic [2*NIB_W-1:0]                  bus,
   output logic [NUM_NIBBLES*NIB_W-SUB_W-1:0]  code,
   output logic                                sub_lsb_err
);

   localparam int unsigned BUS_W  = 2 * NIB_W;
   localparam int unsigned REG_W  = NUM_NIBBLES * NIB_W;
   localparam int unsigned CODE_W = REG_W - SUB_W;
   localparam int unsigned CAP_W  = 2 + BUS_W;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (SUB_W == 0 || SUB_W >= NIB_W) begin : g_bad_sub
      $error("SUB_W must lie between 1 and NIB_W-1");
   end

   logic cs_s, wr_s, ld_s, clr_s;
   logic [CAP_W-1:0] cap_d;

   dacif_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'hF)) u_sync_ctl (
      .clk   (clk),
      .rst_n (por_n),
      .d     ({cs_n, wr_n, ld_n, clr_n}),
      .q     ({cs_s, wr_s, ld_s, clr_s})
   );

   // Address and data ride an equal-depth pipeline so they stay aligned with the strobes.
   dacif_sync #(.W(CAP_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_dat (
      .clk   (clk),
      .rst_n (por_n),
      .d     ({addr, bus}),
      .q     (cap_d)
   );

   logic             wr_prev, cs_prev;
   logic [1:0]       addr_prev;
   logic [BUS_W-1:0] bus_prev;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         wr_prev   <= 1'b1;
         cs_prev   <= 1'b1;
         addr_prev <= '0;
         bus_prev  <= '0;
      end else begin
         wr_prev   <= wr_s;
         cs_prev   <= cs_s;
         addr_prev <= cap_d[CAP_W-1 -: 2];
         bus_prev  <= cap_d[BUS_W-1:0];
      end
   end

   logic commit;
   assign commit = wr_s && !wr_prev && !cs_prev && clr_s;

   logic [REG_W-1:0] in_reg;

   dacif_input_reg #(.NIB_W(NIB_W), .SUB_W(SUB_W)) u_in (
      .clk     (clk),
      .rst_n   (por_n),
      .wr_en   (commit),
      .sel     (nib_sel_e'(addr_prev)),
      .data    (bus_prev),
      .in_reg  (in_reg),
      .sub_err (sub_lsb_err)
   );

   logic out_rst_n;
   assign out_rst_n = por_n & clr_n;

   dacif_output_reg #(.CODE_W(CODE_W)) u_out (
      .clk    (clk),
      .rst_n  (out_rst_n),
      .follow (!ld_s),
      .src    (in_reg[REG_W-1:SUB_W]),
      .code   (code)
   );

endmodule

// File: rtl/dacif_checker.sv
module dacif_checker #(
   parameter int unsigned REG_W = 12,
   parameter int unsigned SUB_W = 2
) (
   input logic             clk,
   input logic             por_n,
   input logic             clr_n,
   input logic             ld_s,
   input logic             wr_s,
   input logic             clr_s,
   input logic [REG_W-1:0] in_reg,
   input logic [REG_W-SUB_W-1:0] code,
   input logic             err
);

   a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (!por_n)
      (ld_s && $past(ld_s) && clr_n && $past(clr_n)) |-> $stable(code));

   a_r8_follow_staging: assert property (@(posedge clk) disable iff (!por_n)
      (!ld_s && clr_n) |=> (!clr_n || code == $past(in_reg[REG_W-1:SUB_W])));

   a_r9_clear_zero: assert property (@(posedge clk) disable iff (!por_n)
      !clr_n |-> code == '0);

   a_r6_no_edge_no_write: assert property (@(posedge clk) disable iff (!por_n)
      (wr_s && $past(wr_s)) |=> $stable(in_reg));

   a_r6_clear_blocks_write: assert property (@(posedge clk) disable iff (!por_n)
      !clr_s |=> $stable(in_reg));

   a_r11_err_sticky: assert property (@(posedge clk) disable iff (!por_n)
      err |=> err);

endmodule

bind dac_nibble_if dacif_checker #(.REG_W(REG_W), .SUB_W(SUB_W)) u_chk (
   .clk    (clk),
   .por_n  (por_n),
   .clr_n  (clr_n),
   .ld_s   (ld_s),
   .wr_s   (wr_s),
   .clr_s  (clr_s),
   .in_reg (in_reg),
   .code   (code),
   .err    (sub_lsb_err)
);

// File: tb/tb_dac_nibble_if.sv
module tb_dac_nibble_if;

   localparam time CLK_P = 8ns;

   logic       clk = 1'b0;
   logic       por_n, cs_n, wr_n, ld_n, clr_n;
   logic [1:0] addr;
   logic [7:0] bus;
   logic [9:0] code;
   logic       sub_lsb_err;

   always #(CLK_P/2) clk = ~clk;

   dac_nibble_if dut (
      .clk(clk), .por_n(por_n), .cs_n(cs_n), .wr_n(wr_n), .ld_n(ld_n),
      .clr_n(clr_n), .addr(addr), .bus(bus), .code(code), .sub_lsb_err(sub_lsb_err)
   );

   typedef struct {
      logic [9:0] code;
      logic       err;
      string      tag;
   } exp_t;

   exp_t exp_q[$];
   int   n_chk  = 0;
   int   n_fail = 0;
   bit   done   = 0;

   // Independent model of the staging register, code and flag.
   logic [11:0] m_in   = '0;
   logic [9:0]  m_code = '0;
   logic        m_err  = 1'b0;

   task automatic expect_now(input string tag);
      exp_t e;
      e.code = m_code; e.err = m_err; e.tag = tag;
      exp_q.push_back(e);
      wait (exp_q.size() == 0);
   endtask

   // Monitor: compares design outputs against queued expectations at falling edges.
   initial begin
      forever begin
         @(negedge clk);
         if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_chk++;
            if (code !== e.code || sub_lsb_err !== e.err) begin
               n_fail++;
               $display("FAIL %s: code=%h err=%b expected code=%h err=%b",
                        e.tag, code, sub_lsb_err, e.code, e.err);
            end
         end
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [7:0] d, input bit sel);
      @(negedge clk);
      addr = a; bus = d; cs_n = !sel; wr_n = 1'b0;
      idle(3);
      wr_n = 1'b1;
      idle(1);
      cs_n = 1'b1;
      idle(5);
      if (sel && clr_n) begin
         case (a)
            2'b11: m_in[11:8] = d[3:0];
            2'b01: m_in[7:4]  = d[7:4];
            2'b10: m_in[3:0]  = d[3:0];
            default: m_in[7:0] = d;
         endcase
         if ((a == 2'b10 || a == 2'b00) && d[1:0] != 2'b00) m_err = 1'b1;
         if (!ld_n) m_code = m_in[11:2];
      end
   endtask

   task automatic load_pulse;
      @(negedge clk);
      ld_n = 1'b0;
      idle(3);
      ld_n = 1'b1;
      idle(5);
      m_code = m_in[11:2];
   endtask

   initial begin
      #(CLK_P * 100000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete, expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      por_n = 1'b0; cs_n = 1'b1; wr_n = 1'b1; ld_n = 1'b1; clr_n = 1'b1;
      addr = '0; bus = '0;
      idle(3);
      por_n = 1'b1;
      idle(4);
      expect_now("R10 reset state");

      // R4, R3, R2 three-nibble load with load strobe high
      bus_write(2'b10, 8'h0C, 1);
      bus_write(2'b01, 8'h50, 1);
      bus_write(2'b11, 8'h0A, 1);
      expect_now("R7 code held before load");
      load_pulse();
      expect_now("R1 R2 R3 R4 nibble routing 0x297");

      // R5 combined 8-bit write, then high nibble with upper lines ignored
      bus_write(2'b00, 8'h38, 1);
      bus_write(2'b11, 8'hF6, 1);
      expect_now("R7 code held across writes");
      load_pulse();
      expect_now("R5 R2 combined load 0x18E");

      // R8 transparent while load low
      @(negedge clk); ld_n = 1'b0;
      idle(4);
      bus_write(2'b11, 8'h01, 1);
      expect_now("R8 high nibble follows while load low");
      @(negedge clk); ld_n = 1'b1;
      idle(4);
      bus_write(2'b11, 8'h0F, 1);
      expect_now("R8 frozen after load release");

      // R6 select high: ignored
      bus_write(2'b01, 8'h90, 0);
      load_pulse();
      expect_now("R6 write with select high ignored");

      // R9 async clear
      @(negedge clk); clr_n = 1'b0;
      #1;
      n_chk++;
      if (code !== 10'h000) begin
         n_fail++;
         $display("FAIL R9 async clear: code=%h expected 000", code);
      end
      m_code = '0;
      bus_write(2'b11, 8'h02, 1);   // R6: blocked by clear
      expect_now("R9 code zero while clear low");
      @(negedge clk); clr_n = 1'b1;
      idle(5);
      expect_now("R9 code stays zero after clear release");
      load_pulse();
      expect_now("R9 R6 staging kept, blocked write dropped");

      // R11 sticky flag
      expect_now("R11 flag clear with zero sub bits");
      bus_write(2'b10, 8'h01, 1);
      load_pulse();
      expect_now("R11 flag set by nonzero sub bit");
      bus_write(2'b10, 8'h08, 1);
      load_pulse();
      expect_now("R11 flag stays set");

      // R10 power-on reset mid-run
      @(negedge clk); por_n = 1'b0;
      m_in = '0; m_code = '0; m_err = 1'b0;
      idle(2);
      por_n = 1'b1;
      idle(4);
      expect_now("R10 reset clears code and flag");
      load_pulse();
      expect_now("R10 staging zeroed");

      // R5 R11 combined write with sub bit set
      bus_write(2'b00, 8'h12, 1);
      load_pulse();
      expect_now("R5 R11 combined write sub bit");

      idle(2);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      done = 1;
      $finish;
   end

endmodule